// File: doc/BRIEF.md
# Link Test Pattern Generator

This block produces a continuous stream of self-describing test frames for the 256-bit transmit side of a high-speed Ethernet-style core, so that a receiver at the far end of a link can detect dropped, reordered or corrupted words. Each emitted word carries several fields:

- its own index within the frame;
- a fixed marker;
- a walking-one bit;
- a frame counter that is the same for every word of one frame;
- a ramp that starts at 1.

The last word of a frame is flagged as end of frame.

The frame length and the idle gap between frames come from configuration inputs. The gap exists to throttle the average word rate when the fabric clock is faster than the core drains its transmit buffer. Separate control inputs pause the stream, stop new frames from starting, and clear the sequence. Two saturating counters record for how many cycles the core reported its transmit buffer almost full and overflowing.

Top module: `lnk_pattern_gen`

## Requirements
- R1: When `tx_valid` is high, `tx_data` holds the word index in bits [15:0], the constant 0x7777 in bits [31:16], the walking-one field in bits [95:32], the frame counter in bits [127:96] and the ramp in bits [159:128]. Bits [255:160] are zero. When `tx_valid` is low, `tx_data` is all zero.
- R2: A frame of N words has indices 0 to N-1 and ramp values 1 to N. `tx_eof` is high together with the word of index N-1 and at no other time.
- R3: The length is taken from `cfg_pkt_words` when a frame starts. A value of 0 gives 1 word, and a value above 256 gives 256 words.
- R4: Exactly one bit of the walking-one field is set. After reset or a frame clear it starts at field bit 0. It moves up one position on every emitted word, also across frame boundaries, and returns to field bit 0 after field bit 63.
- R5: The frame counter is 0 for the first frame after reset or a frame clear. It is constant within a frame and increases by one for each following frame.
- R6: While `ctl_pkt_en` and `ctl_tx_en` stay high, exactly `cfg_gap` cycles with `tx_valid` low separate the end-of-frame word from the first word of the next frame. A gap of 0 gives back-to-back frames.
- R7: When `ctl_pkt_en` goes low, the frame in progress still completes with its end-of-frame word, and no further frame starts.
- R8: While `ctl_tx_en` is low, `tx_valid` is low from the next cycle and the sequence is frozen. When it returns high, output resumes with the word that was due next.
- R9: `ctl_pkt_rst` forces `tx_valid` low in the next cycle and returns the generator to idle, with the frame counter and the walking-one position cleared.
- R10: `afull_cnt` and `ovf_cnt` each increase by one for every cycle in which `core_afull` or `core_ovf` respectively is high. The new value is visible one cycle later. Each counter holds at its all-ones value instead of wrapping.
- R11: `ctl_cnt_clr` zeroes both event counters in the next cycle and takes priority over a flag that is high in the same cycle.
- R12: While `rst_n` is low at a clock edge, the next state has `tx_valid`, `tx_eof`, `tx_data` and both counters at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fabric clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_pkt_rst | input | 1 | Frame clear: sequencer to idle, counters of the pattern zeroed |
| ctl_cnt_clr | input | 1 | Clear both event counters |
| ctl_tx_en | input | 1 | Transmit enable; low freezes the stream |
| ctl_pkt_en | input | 1 | Frame enable; low lets the current frame finish and starts no new one |
| cfg_pkt_words | input | 16 | Frame length in words (clamped to 1..256) |
| cfg_gap | input | 16 | Idle cycles between frames |
| core_afull | input | 1 | Core transmit buffer almost full |
| core_ovf | input | 1 | Core transmit buffer overflow |
| tx_data | output | 256 | Data word to the core |
| tx_valid | output | 1 | Word valid |
| tx_eof | output | 1 | Last word of the frame |
| afull_cnt | output | CNT_W (32) | Cycles with almost-full seen |
| ovf_cnt | output | CNT_W (32) | Cycles with overflow seen |

## Verification
The properties assume that `rst_n` is held low for at least one edge before any check matters. They also assume that the control inputs change only between edges. Every control input may take any value in any cycle: the chains of consecutive-word properties are broken on purpose by pauses, clears and frame ends, so no input ordering is assumed. The stimulus drives all inputs on the falling clock edge. It starts each vector with a frame clear so that counter and walking-one expectations start from zero. It also uses a 4-bit event counter width so that saturation is reached within a few cycles.

// File: rtl/lnk_pkg.sv
package lnk_pkg;

    // Field geometry of one pattern word; the receiver decodes these positions.
    localparam int IDX_W   = 16;
    localparam int MARK_W  = 16;
    localparam int WALK_W  = 64;
    localparam int PKT_W   = 32;
    localparam int RAMP_W  = 32;

    localparam int IDX_LO  = 0;
    localparam int MARK_LO = IDX_LO + IDX_W;
    localparam int WALK_LO = MARK_LO + MARK_W;
    localparam int PKT_LO  = WALK_LO + WALK_W;
    localparam int RAMP_LO = PKT_LO + PKT_W;
    localparam int USED_W  = RAMP_LO + RAMP_W;

    localparam logic [MARK_W-1:0] MARKER = 16'h7777;

    localparam int WALK_IDX_W = $clog2(WALK_W);

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SEND = 2'd1,
        ST_GAP  = 2'd2
    } seq_st_e;

endpackage

// File: rtl/lnk_seq.sv
module lnk_seq
    import lnk_pkg::*;
#(
    parameter int MAX_WORDS = 256,
    parameter int CFG_W     = 16,
    parameter int GAP_W     = 16,
    parameter int LEN_W     = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  pkt_rst,
    input  logic                  tx_en,
    input  logic                  pkt_en,
    input  logic [CFG_W-1:0]      cfg_len,
    input  logic [GAP_W-1:0]      cfg_gap,
    output logic                  fire,
    output logic                  last,
    output logic [LEN_W-1:0]      widx,
    output logic [PKT_W-1:0]      pkt,
    output logic [WALK_IDX_W-1:0] walk
);

    typedef struct packed {
        seq_st_e                st;
        logic [LEN_W-1:0]       widx;
        logic [LEN_W-1:0]       len;
        logic [GAP_W-1:0]       gcnt;
        logic [PKT_W-1:0]       pkt;
        logic [WALK_IDX_W-1:0]  walk;
    } seq_s;

    seq_s             seq_d, seq_q;
    logic [LEN_W-1:0] len_clamp;
    logic             is_last;

    always_comb begin
        if (cfg_len == '0) begin
            len_clamp = LEN_W'(1);
        end else if (cfg_len > CFG_W'(MAX_WORDS)) begin
            len_clamp = LEN_W'(MAX_WORDS);
        end else begin
            len_clamp = cfg_len[LEN_W-1:0];
        end
    end

    assign is_last = (seq_q.widx == seq_q.len - LEN_W'(1));

    always_comb begin
        seq_d = seq_q;
        fire  = 1'b0;
        last  = 1'b0;
        if (pkt_rst) begin
            seq_d    = '0;
            seq_d.st = ST_IDLE;
        end else if (tx_en) begin
            unique case (seq_q.st)
                ST_IDLE: begin
                    if (pkt_en) begin
                        seq_d.st   = ST_SEND;
                        seq_d.widx = '0;
                        seq_d.len  = len_clamp;
                    end
                end
                ST_SEND: begin
                    fire       = 1'b1;
                    last       = is_last;
                    seq_d.walk = (seq_q.walk == WALK_IDX_W'(WALK_W - 1))
                                 ? '0 : seq_q.walk + WALK_IDX_W'(1);
                    if (is_last) begin
                        seq_d.pkt  = seq_q.pkt + PKT_W'(1);
                        seq_d.widx = '0;
                        if (cfg_gap != '0) begin
                            seq_d.st   = ST_GAP;
                            seq_d.gcnt = cfg_gap;
                        end else if (pkt_en) begin
                            seq_d.st  = ST_SEND;
                            seq_d.len = len_clamp;
                        end else begin
                            seq_d.st = ST_IDLE;
                        end
                    end else begin
                        seq_d.widx = seq_q.widx + LEN_W'(1);
                    end
                end
                ST_GAP: begin
                    if (seq_q.gcnt == GAP_W'(1)) begin
                        if (pkt_en) begin
                            seq_d.st   = ST_SEND;
                            seq_d.widx = '0;
                            seq_d.len  = len_clamp;
                        end else begin
                            seq_d.st = ST_IDLE;
                        end
                    end else begin
                        seq_d.gcnt = seq_q.gcnt - GAP_W'(1);
                    end
                end
                default: seq_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq_q    <= '0;
            seq_q.st <= ST_IDLE;
        end else begin
            seq_q <= seq_d;
        end
    end

    assign widx = seq_q.widx;
    assign pkt  = seq_q.pkt;
    assign walk = seq_q.walk;

    // R6: a gap count of zero never lingers in the gap state
    p_gap_nonzero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_GAP) |-> (seq_q.gcnt != '0));

    // R3: the latched length stays within 1..MAX_WORDS while sending
    p_len_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_q.st == ST_SEND) |-> (seq_q.len != '0 && seq_q.len <= LEN_W'(MAX_WORDS)));

    // R8: a frozen cycle keeps the whole sequence state
    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !pkt_rst) |=> $stable(seq_q));

endmodule

// File: rtl/lnk_word_fmt.sv
module lnk_word_fmt
    import lnk_pkg::*;
#(
    parameter int DATA_W = 256,
    parameter int LEN_W  = 9
) (
    input  logic [LEN_W-1:0]      widx,
    input  logic [PKT_W-1:0]      pkt,
    input  logic [WALK_IDX_W-1:0] walk,
    output logic [DATA_W-1:0]     word
);

    localparam int PAD_W = DATA_W - USED_W;

    logic [USED_W-1:0] fields;

    always_comb begin
        fields                       = '0;
        fields[IDX_LO  +: IDX_W]     = IDX_W'(widx);
        fields[MARK_LO +: MARK_W]    = MARKER;
        fields[WALK_LO +: WALK_W]    = WALK_W'(1) << walk;
        fields[PKT_LO  +: PKT_W]     = pkt;
        fields[RAMP_LO +: RAMP_W]    = RAMP_W'(widx) + RAMP_W'(1);
    end

    generate
        if (PAD_W > 0) begin : g_pad
            assign word = {{PAD_W{1'b0}}, fields};
        end else begin : g_exact
            assign word = fields[DATA_W-1:0];
        end
    endgenerate

endmodule

// File: rtl/lnk_evt_cnt.sv
module lnk_evt_cnt #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             evt,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (evt && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt && !clr && cnt_q != CNT_MAX) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

    p_cnt_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_MAX && !clr) |=> (cnt_q == CNT_MAX));

    p_cnt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!evt && !clr) |=> $stable(cnt_q));

    p_cnt_clr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

endmodule

// File: rtl/lnk_pattern_gen.sv
module lnk_pattern_gen
    import lnk_pkg::*;
#(
    parameter int DATA_W    = 256,
    parameter int MAX_WORDS = 256,
    parameter int CFG_W     = 16,
    parameter int GAP_W     = 16,
    parameter int CNT_W     = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_pkt_rst,
    input  logic              ctl_cnt_clr,
    input  logic              ctl_tx_en,
    input  logic              ctl_pkt_en,
    input  logic [CFG_W-1:0]  cfg_pkt_words,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              core_afull,
    input  logic              core_ovf,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_valid,
    output logic              tx_eof,
    output logic [CNT_W-1:0]  afull_cnt,
    output logic [CNT_W-1:0]  ovf_cnt
);

    localparam int LEN_W  = $clog2(MAX_WORDS + 1);
    localparam int N_EVT  = 2;

    typedef struct packed {
        logic              valid;
        logic              eof;
        logic [DATA_W-1:0] data;
    } out_s;

    logic                  fire, last;
    logic [LEN_W-1:0]      widx;
    logic [PKT_W-1:0]      pkt;
    logic [WALK_IDX_W-1:0] walk;
    logic [DATA_W-1:0]     word;
    out_s                  out_d, out_q;

    lnk_seq #(
        .MAX_WORDS (MAX_WORDS),
        .CFG_W     (CFG_W),
        .GAP_W     (GAP_W),
        .LEN_W     (LEN_W)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .pkt_rst (ctl_pkt_rst),
        .tx_en   (ctl_tx_en),
        .pkt_en  (ctl_pkt_en),
        .cfg_len (cfg_pkt_words),
        .cfg_gap (cfg_gap),
        .fire    (fire),
        .last    (last),
        .widx    (widx),
        .pkt     (pkt),
        .walk    (walk)
    );

    lnk_word_fmt #(
        .DATA_W (DATA_W),
        .LEN_W  (LEN_W)
    ) u_fmt (
        .widx (widx),
        .pkt  (pkt),
        .walk (walk),
        .word (word)
    );

    always_comb begin
        out_d.valid = fire;
        out_d.eof   = fire & last;
        out_d.data  = fire ? word : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign tx_valid = out_q.valid;
    assign tx_eof   = out_q.eof;
    assign tx_data  = out_q.data;

    logic [N_EVT-1:0] evt_flags;
    logic [CNT_W-1:0] evt_cnt [N_EVT];

    assign evt_flags = {core_ovf, core_afull};

    generate
        for (genvar g = 0; g < N_EVT; g++) begin : g_evt
            lnk_evt_cnt #(
                .CNT_W (CNT_W)
            ) u_cnt (
                .clk   (clk),
                .rst_n (rst_n),
                .clr   (ctl_cnt_clr),
                .evt   (evt_flags[g]),
                .cnt   (evt_cnt[g])
            );
        end
    endgenerate

    assign afull_cnt = evt_cnt[0];
    assign ovf_cnt   = evt_cnt[1];

    p_eof_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        tx_eof |-> tx_valid);

    p_marker_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (tx_data[MARK_LO +: MARK_W] == MARKER));

    p_idle_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_valid |-> (tx_data == '0));

    p_ramp_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid) && !$past(tx_eof)) |->
        (tx_data[RAMP_LO +: RAMP_W] == $past(tx_data[RAMP_LO +: RAMP_W]) + RAMP_W'(1)));

    p_walk_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> ($countones(tx_data[WALK_LO +: WALK_W]) == 1));

    p_walk_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid)) |->
        (tx_data[WALK_LO +: WALK_W] ==
         {$past(tx_data[WALK_LO +: WALK_W - 1]), $past(tx_data[WALK_LO + WALK_W - 1])}));

    p_pkt_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && $past(tx_valid) && !$past(tx_eof)) |->
        (tx_data[PKT_LO +: PKT_W] == $past(tx_data[PKT_LO +: PKT_W])));

    p_txen_stall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl_tx_en |=> !tx_valid);

    p_pkt_rst_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_pkt_rst |=> !tx_valid);

endmodule

// File: tb/lnk_pattern_gen_bench.sv
module lnk_pattern_gen_bench;

    localparam int NVEC  = 6;
    localparam int CNT_W = 4;
    localparam int WD    = 150000;

    localparam logic [15:0] V_LEN [NVEC] = '{16'd4, 16'd1, 16'd0, 16'd300, 16'd160, 16'd7};
    localparam logic [15:0] V_GAP [NVEC] = '{16'd3, 16'd0, 16'd2, 16'd1,   16'd0,   16'd5};
    localparam int          V_EXP [NVEC] = '{4,     1,     1,     256,     160,     7};

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_pkt_rst = 1'b0;
    logic             ctl_cnt_clr = 1'b0;
    logic             ctl_tx_en = 1'b0;
    logic             ctl_pkt_en = 1'b0;
    logic [15:0]      cfg_pkt_words = 16'd4;
    logic [15:0]      cfg_gap = 16'd0;
    logic             core_afull = 1'b0;
    logic             core_ovf = 1'b0;
    logic [255:0]     tx_data;
    logic             tx_valid;
    logic             tx_eof;
    logic [CNT_W-1:0] afull_cnt;
    logic [CNT_W-1:0] ovf_cnt;

    int  nchk = 0;
    int  nfail = 0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    lnk_pattern_gen #(.CNT_W(CNT_W)) u_lnk_pattern_gen (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctl_pkt_rst   (ctl_pkt_rst),
        .ctl_cnt_clr   (ctl_cnt_clr),
        .ctl_tx_en     (ctl_tx_en),
        .ctl_pkt_en    (ctl_pkt_en),
        .cfg_pkt_words (cfg_pkt_words),
        .cfg_gap       (cfg_gap),
        .core_afull    (core_afull),
        .core_ovf      (core_ovf),
        .tx_data       (tx_data),
        .tx_valid      (tx_valid),
        .tx_eof        (tx_eof),
        .afull_cnt     (afull_cnt),
        .ovf_cnt       (ovf_cnt)
    );

    function automatic logic [255:0] exp_word(int idx, int pk, int wb);
        logic [255:0] w;
        w              = '0;
        w[15:0]        = 16'(idx);
        w[31:16]       = 16'h7777;
        w[32 + wb]     = 1'b1;
        w[127:96]      = 32'(pk);
        w[159:128]     = 32'(idx + 1);
        return w;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    endtask

    initial begin
        repeat (WD) @(posedge clk);
        if (!done) begin
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        int idx, pk, wb, seen, rem;

        // R12: reset state
        repeat (3) @(negedge clk);
        chk(!tx_valid && !tx_eof, "R12", "valid/eof in reset", {254'd0, tx_valid, tx_eof}, '0);
        chk(tx_data == '0, "R12", "data in reset", tx_data, '0);
        chk(afull_cnt == 0 && ovf_cnt == 0, "R12", "counters in reset",
            256'({afull_cnt, ovf_cnt}), '0);
        rst_n = 1'b1;
        ctl_tx_en = 1'b1;

        // Vector table: R1 R2 R3 R4 R5 R6 R7
        for (int v = 0; v < NVEC; v++) begin
            int  idle, pkts, last_eof;
            @(negedge clk);
            cfg_pkt_words = V_LEN[v];
            cfg_gap       = V_GAP[v];
            ctl_pkt_rst   = 1'b1;
            ctl_pkt_en    = 1'b0;
            @(negedge clk);
            ctl_pkt_rst = 1'b0;
            ctl_pkt_en  = 1'b1;
            idx = 0; pk = 0; wb = 0; idle = 0; pkts = 0; last_eof = 0;
            for (int c = 0; c < 3000; c++) begin
                @(negedge clk);
                if (tx_valid) begin
                    chk(tx_data == exp_word(idx, pk, wb), "R1 R4 R5", "word content",
                        tx_data, exp_word(idx, pk, wb));
                    chk(tx_eof == (idx == V_EXP[v] - 1), "R2 R3", "eof position",
                        256'(tx_eof), 256'(idx == V_EXP[v] - 1));
                    if (pkts > 0 && idx == 0)
                        chk(idle == int'(V_GAP[v]), "R6", "gap length",
                            256'(idle), 256'(V_GAP[v]));
                    wb = (wb + 1) % 64;
                    idle = 0;
                    last_eof = tx_eof;
                    if (tx_eof) begin
                        pkts++; pk++; idx = 0;
                        if (pkts == 2) ctl_pkt_en = 1'b0;
                    end else begin
                        idx++;
                    end
                end else begin
                    idle++;
                    if (pkts >= 2 && idle > int'(V_GAP[v]) + 3) break;
                end
            end
            chk(pkts >= 2 && last_eof == 1, "R7", "stream ends on a whole frame",
                256'(pkts), 256'(2));
        end

        // R8: pause mid-frame, then resume with the next word
        @(negedge clk);
        cfg_pkt_words = 16'd8; cfg_gap = 16'd0;
        ctl_pkt_rst = 1'b1; ctl_pkt_en = 1'b0;
        @(negedge clk);
        ctl_pkt_rst = 1'b0; ctl_pkt_en = 1'b1;
        seen = 0;
        for (int c = 0; c < 50 && seen < 3; c++) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        ctl_tx_en = 1'b0;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            chk(!tx_valid, "R8", "no word while paused", 256'(tx_valid), '0);
        end
        ctl_tx_en = 1'b1;
        for (int c = 0; c < 10 && !tx_valid; c++) @(negedge clk);
        chk(tx_data == exp_word(3, 0, 3), "R8", "resume word", tx_data, exp_word(3, 0, 3));

        // R9: frame clear mid-frame
        ctl_pkt_rst = 1'b1;
        @(negedge clk);
        chk(!tx_valid, "R9", "valid after clear", 256'(tx_valid), '0);
        ctl_pkt_rst = 1'b0;
        for (int c = 0; c < 10 && !tx_valid; c++) @(negedge clk);
        chk(tx_data == exp_word(0, 0, 0), "R9", "first word after clear",
            tx_data, exp_word(0, 0, 0));

        // R7: drop frame enable after first word; frame still completes
        ctl_pkt_en = 1'b0;
        rem = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (tx_valid) begin
                rem++;
                if (tx_eof) break;
            end
        end
        chk(rem == 7 && tx_eof, "R7", "remaining words of frame", 256'(rem), 256'(7));
        seen = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (tx_valid) seen++;
        end
        chk(seen == 0, "R7", "no new frame", 256'(seen), '0);

        // R10: event counting
        core_afull = 1'b1; core_ovf = 1'b1;
        for (int c = 0; c < 5; c++) begin
            @(negedge clk);
            if (c == 2) core_ovf = 1'b0;
        end
        core_afull = 1'b0;
        @(negedge clk);
        chk(afull_cnt == 5, "R10", "almost-full count", 256'(afull_cnt), 256'(5));
        chk(ovf_cnt == 3, "R10", "overflow count", 256'(ovf_cnt), 256'(3));

        // R11: clear wins over a simultaneous flag
        ctl_cnt_clr = 1'b1; core_afull = 1'b1;
        @(negedge clk);
        ctl_cnt_clr = 1'b0; core_afull = 1'b0;
        chk(afull_cnt == 0 && ovf_cnt == 0, "R11", "counters after clear",
            256'({afull_cnt, ovf_cnt}), '0);

        // R10: saturation
        core_ovf = 1'b1;
        repeat (20) @(negedge clk);
        core_ovf = 1'b0;
        @(negedge clk);
        chk(ovf_cnt == 15, "R10", "saturated count", 256'(ovf_cnt), 256'(15));
        chk(afull_cnt == 0, "R10", "other counter untouched", 256'(afull_cnt), '0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule